// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block sequences sense and burn operations on a one-time-programmable fuse array. Software uses it through a small word-addressed register bus. The fuse array is modelled as a memory whose bits can only go from 0 to 1. The memory has no reset, so burned values survive a reset of the controller. Each fuse word also has a shadow register. After reset, and after every successful burn, the shadow register is reloaded from the array. Software may overwrite a shadow register at any time to override the value seen at that address, and no fuse is touched when it does.

An operation has three phases: a relax guard, an active strobe and a second relax guard. Each phase is counted in clock cycles from the fields of a timing register. A sense returns the raw fuse word in a read-data register. A burn ORs a data word into the addressed fuse word. A burn is accepted only while a 16-bit unlock key sits in the control register. Misuse raises a sticky error flag: a missing key, an address beyond the array, or a new request while an operation runs.

Register offsets (byte addresses, 32-bit words):
- control: 0x000
- control set alias: 0x004
- control clear alias: 0x008
- timing: 0x010
- sense-start: 0x020
- sense-data: 0x030
- burn-data: 0x040
- shadow word i: 0x400 + 4·i

Top module: `otp_fuse_ctrl`

## Requirements
- R1: While reset is held and for 2·NUM_WORDS cycles after it is released, busy is high while every shadow register reloads from the fuse array. After that, the control register reads 0 (unlock field zero, no error) and each shadow word equals its fuse word, including words burned before the reset.
- R2: Control register layout:
  - bits 31:16: unlock field
  - bit 9: error flag
  - bit 8: busy, read-only
  - bits 6:0: fuse word address
  
  A plain write to offset 0x000 loads the unlock and address fields. The set alias ORs the written bits into the unlock, error and address fields. The clear alias clears them. A 1 written to bit 8 through any alias has no effect. Every register read returns its value on bus_rdata one cycle after bus_rd.
- R3: The error flag is sticky. It stays set through later reads, writes and operations until a 1 is written to bit 9 of the clear alias. Writing 0 to that bit leaves it set.
- R4: Writing a word with bit 0 set to the sense-start register starts a sense of the addressed word. In the cycle busy falls, the sense-data register (0x030) holds the raw fuse word, and it holds that value until the next sense completes.
- R5: Timing register fields, in clock cycles:
  - bits 21:16: read strobe count S (sense)
  - bits 15:12: relax count X
  - bits 11:0: burn strobe count S (burn)
  
  An operation asserts fuse_strobe only after X+1 busy cycles. fuse_strobe then stays high for max(1, S − 2·(X+1) + 1) cycles and is followed by X+1 more relax cycles. Busy stays high for those three phases plus 2 cycles.
- R6: A write to the burn-data register (0x040) starts a burn only when the unlock field equals 0x3E77. Otherwise busy stays low, the error flag is set and the fuse word is left unchanged.
- R7: A burn ORs the written data into the fuse word. No fuse bit is ever cleared.
- R8: After a burn completes, the shadow register of that word equals the new fuse word, replacing any value software wrote there.
- R9: Writing a shadow register changes what that shadow address reads back. It does not change the fuse word that a sense returns.
- R10: A sense-start (bit 0 set) or burn-data write while busy is high is ignored and sets the error flag. The running operation finishes unchanged.
- R11: A sense or burn request whose control address is NUM_WORDS or more does not start (busy stays low) and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 12 | register byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid the cycle after bus_rd |
| busy | output | 1 | an operation or the post-reset reload is in progress |
| error | output | 1 | sticky error flag |
| fuse_strobe | output | 1 | active strobe phase of a sense or burn |

## Verification
The bench measures the relax, strobe and busy lengths of each operation by cycle counting, including a timing setting where the strobe count is smaller than the two relax guards. A timer that miscounted a phase or failed to clamp would give a strobe or busy length that is off by one or more. The bench writes a shadow register and then senses the same word. A design that routed the sense through the shadow would return the override instead of the fuse value. It then burns again and expects the override to be replaced. It also issues burns with no key, with an address beyond the array, and on top of a running operation. A design that burned anyway, or dropped or cleared the error flag, would show a changed word or a wrong flag. A final reset checks that burned values come back through the reload.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int REG_AW = 12;
  localparam int SR_W   = 6;
  localparam int RX_W   = 4;
  localparam int SP_W   = 12;

  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h000;
  localparam logic [REG_AW-1:0] OFS_CSET = 12'h004;
  localparam logic [REG_AW-1:0] OFS_CCLR = 12'h008;
  localparam logic [REG_AW-1:0] OFS_TIME = 12'h010;
  localparam logic [REG_AW-1:0] OFS_SNS  = 12'h020;
  localparam logic [REG_AW-1:0] OFS_SDAT = 12'h030;
  localparam logic [REG_AW-1:0] OFS_PDAT = 12'h040;
  localparam logic [1:0]        SHADOW_PAGE = 2'b01;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] TIME_MASK  = 32'h003F_FFFF;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_ACT, PH_POST} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FETCH, ST_LOAD} state_e;
  typedef enum logic [1:0] {OP_INIT, OP_SENSE, OP_PROG} op_e;
endpackage

// File: rtl/otp_phase_timer.sv
module otp_phase_timer
  import otp_pkg::*;
#(
  parameter int CW = SP_W,
  parameter int RW = RX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] strobe_len,
  input  logic [RW-1:0] relax_len,
  output logic          strobe_on,
  output logic          done
);
  localparam int SW = CW + 2;

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [RW-1:0] relax_q;
  logic [CW-1:0] act_q;
  logic signed [SW-1:0] act_raw;
  logic [CW-1:0] act_len;

  // active = S - 2*(X+1) + 1 = S - 2X - 1, clamped to at least one cycle
  assign act_raw = $signed({2'b00, strobe_len})
                 - $signed({{(SW-RW-1){1'b0}}, relax_len, 1'b0})
                 - $signed(SW'(1));
  assign act_len = (act_raw < $signed(SW'(1))) ? CW'(1) : act_raw[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      relax_q <= '0;
      act_q   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_PRE;
          cnt     <= {{(CW-RW){1'b0}}, relax_len};
          relax_q <= relax_len;
          act_q   <= act_len;
        end
        PH_PRE: if (cnt == '0) begin
          phase <= PH_ACT;
          cnt   <= act_q - CW'(1);
        end else cnt <= cnt - CW'(1);
        PH_ACT: if (cnt == '0) begin
          phase <= PH_POST;
          cnt   <= {{(CW-RW){1'b0}}, relax_q};
        end else cnt <= cnt - CW'(1);
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - CW'(1);
      endcase
    end
  end

  assign strobe_on = (phase == PH_ACT);
  assign done      = (phase == PH_POST) && (cnt == '0);
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int DW    = 32,
  parameter int WORDS = 16,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  // unburned fuses read zero; the array is not cleared by reset
  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= mem[waddr] | wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/otp_shadow_bank.sv
module otp_shadow_bank #(
  parameter int DW    = 32,
  parameter int WORDS = 16,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          sw_en,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                  word_q[g] <= '0;
      else if (ld_en && ld_addr == AW'(g))      word_q[g] <= ld_data;
      else if (sw_en && sw_addr == AW'(g))      word_q[g] <= sw_data;
    end
  end

  assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int          NUM_WORDS   = 16,
  parameter int          DW          = 32,
  parameter logic [31:0] TIMING_INIT = 32'h0008_100A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              error,
  output logic              fuse_strobe
);
  localparam int WAW = $clog2(NUM_WORDS);
  localparam logic [WAW-1:0] LAST = WAW'(NUM_WORDS - 1);

  state_e        state;
  op_e           op;
  logic [WAW-1:0] op_addr;
  logic [DW-1:0] pdata_q;
  logic [DW-1:0] sense_q;
  logic [15:0]   unlock_q;
  logic [6:0]    addr_q;
  logic          err_q;
  logic [31:0]   tim_q;

  logic          busy_w, addr_ok, sh_hit;
  logic [7:0]    sh_idx;
  logic          sense_req, prog_req, sense_go, prog_go, err_evt;
  logic          t_done, t_strobe;
  logic [SP_W-1:0] t_len;
  logic [DW-1:0] arr_rdata, sh_rdata;
  logic          wr_ctrl, wr_cset, wr_cclr;

  assign busy_w    = (state != ST_IDLE);
  assign addr_ok   = {1'b0, addr_q} < 8'(NUM_WORDS);
  assign sh_idx    = bus_addr[9:2];
  assign sh_hit    = (bus_addr[11:10] == SHADOW_PAGE) && (bus_addr[1:0] == 2'b00)
                   && ({1'b0, sh_idx} < 9'(NUM_WORDS));
  assign wr_ctrl   = bus_wr && bus_addr == OFS_CTRL;
  assign wr_cset   = bus_wr && bus_addr == OFS_CSET;
  assign wr_cclr   = bus_wr && bus_addr == OFS_CCLR;
  assign sense_req = bus_wr && bus_addr == OFS_SNS && bus_wdata[0];
  assign prog_req  = bus_wr && bus_addr == OFS_PDAT;
  assign sense_go  = sense_req && !busy_w && addr_ok;
  assign prog_go   = prog_req && !busy_w && addr_ok && unlock_q == UNLOCK_KEY;
  assign err_evt   = (sense_req || prog_req) && !(sense_go || prog_go);
  assign t_len     = sense_go ? {{(SP_W-SR_W){1'b0}}, tim_q[21:16]} : tim_q[11:0];

  otp_phase_timer #(.CW(SP_W), .RW(RX_W)) u_timer (
    .clk(clk), .rst(rst), .start(sense_go || prog_go),
    .strobe_len(t_len), .relax_len(tim_q[15:12]),
    .strobe_on(t_strobe), .done(t_done)
  );

  otp_fuse_array #(.DW(DW), .WORDS(NUM_WORDS), .AW(WAW)) u_array (
    .clk(clk),
    .we(state == ST_RUN && t_done && op == OP_PROG),
    .waddr(op_addr), .wdata(pdata_q),
    .re(state == ST_FETCH), .raddr(op_addr), .rdata(arr_rdata)
  );

  otp_shadow_bank #(.DW(DW), .WORDS(NUM_WORDS), .AW(WAW)) u_shadow (
    .clk(clk), .rst(rst),
    .ld_en(state == ST_LOAD && op != OP_SENSE), .ld_addr(op_addr), .ld_data(arr_rdata),
    .sw_en(bus_wr && sh_hit), .sw_addr(sh_idx[WAW-1:0]), .sw_data(bus_wdata),
    .rd_addr(sh_idx[WAW-1:0]), .rd_data(sh_rdata)
  );

  // operation sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      op      <= OP_INIT;
      op_addr <= '0;
      pdata_q <= '0;
      sense_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sense_go) begin
            state   <= ST_RUN;
            op      <= OP_SENSE;
            op_addr <= addr_q[WAW-1:0];
          end else if (prog_go) begin
            state   <= ST_RUN;
            op      <= OP_PROG;
            op_addr <= addr_q[WAW-1:0];
            pdata_q <= bus_wdata;
          end
        end
        ST_RUN:   if (t_done) state <= ST_FETCH;
        ST_FETCH: state <= ST_LOAD;
        default: begin
          if (op == OP_SENSE) sense_q <= arr_rdata;
          if (op == OP_INIT && op_addr != LAST) begin
            op_addr <= op_addr + WAW'(1);
            state   <= ST_FETCH;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // control and timing registers
  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= '0;
      addr_q   <= '0;
      err_q    <= 1'b0;
      tim_q    <= TIMING_INIT & TIME_MASK;
    end else begin
      if (wr_ctrl) begin
        unlock_q <= bus_wdata[31:16];
        addr_q   <= bus_wdata[6:0];
      end
      if (wr_cset) begin
        unlock_q <= unlock_q | bus_wdata[31:16];
        addr_q   <= addr_q | bus_wdata[6:0];
        err_q    <= err_q | bus_wdata[9];
      end
      if (wr_cclr) begin
        unlock_q <= unlock_q & ~bus_wdata[31:16];
        addr_q   <= addr_q & ~bus_wdata[6:0];
        err_q    <= err_q & ~bus_wdata[9];
      end
      if (err_evt) err_q <= 1'b1;
      if (bus_wr && bus_addr == OFS_TIME) tim_q <= bus_wdata & TIME_MASK;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL, OFS_CSET, OFS_CCLR:
                  bus_rdata <= {unlock_q, 6'b0, err_q, busy_w, 1'b0, addr_q};
        OFS_TIME: bus_rdata <= tim_q;
        OFS_SDAT: bus_rdata <= 32'(sense_q);
        default:  bus_rdata <= sh_hit ? 32'(sh_rdata) : 32'h0;
      endcase
    end
  end

  assign busy        = busy_w;
  assign error       = err_q;
  assign fuse_strobe = t_strobe;
endmodule

// File: rtl/otp_fuse_ctrl_sva.sv
module otp_fuse_ctrl_sva
  import otp_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              busy,
  input logic              error,
  input logic              fuse_strobe,
  input logic [15:0]       unlock,
  input logic [DW-1:0]     sense_data
);
  AST_STROBE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    fuse_strobe |-> busy); // R5

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (error && !(bus_wr && bus_addr == OFS_CCLR && bus_wdata[9])) |=> error); // R3

  AST_NO_BURN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && bus_wr && bus_addr == OFS_PDAT && unlock != UNLOCK_KEY) |=> (!busy && error)); // R6

  AST_BUSY_REQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && bus_addr == OFS_SNS && bus_wdata[0]) |=> error); // R10

  AST_SENSE_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(sense_data)); // R4
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .busy(busy), .error(error), .fuse_strobe(fuse_strobe),
  .unlock(unlock_q), .sense_data(sense_q)
);

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;
  localparam int NW = 16;
  localparam logic [11:0] A_CTRL = 12'h000, A_CSET = 12'h004, A_CCLR = 12'h008,
                          A_TIME = 12'h010, A_SNS = 12'h020, A_SDAT = 12'h030,
                          A_PDAT = 12'h040;

  logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         busy, error, fuse_strobe;

  always #10 clk = ~clk;

  otp_fuse_ctrl #(.NUM_WORDS(NW)) i_otp_fuse_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .error(error),
    .fuse_strobe(fuse_strobe)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_err = 0;
  logic rd_q = 1'b0;
  bit   done_flag = 0;

  always @(posedge clk) rd_q <= bus_rd;

  // monitor: compares each read result against the expectation queued by the driver
  always @(negedge clk) begin
    if (rd_q) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_err++;
        $display("FAIL scoreboard: read result %h with no expectation", bus_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (bus_rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s: rdata %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; sb.push_back(it);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic measure(output int nb, output int ns, output int npre);
    nb = 0; ns = 0; npre = 0;
    while (busy && nb < 10000) begin
      nb++;
      if (fuse_strobe) ns++;
      else if (ns == 0) npre++;
      @(negedge clk);
    end
  endtask

  task automatic op_len(input string tag, input int eb, input int es, input int ep);
    int nb, ns, np;
    measure(nb, ns, np);
    chk(nb == eb, {tag, " busy cycles"}, nb, eb);
    chk(ns == es, {tag, " strobe cycles"}, ns, es);
    chk(np == ep, {tag, " relax before strobe"}, np, ep);
  endtask

  task automatic reset_seq();
    int nb, ns, np;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    measure(nb, ns, np);
    chk(nb == 2 * NW, "R1 reload busy cycles", nb, 2 * NW);
    chk(error == 1'b0, "R1 error after reset", error, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    reset_seq();
    rd_exp(A_CTRL, 32'h0, "R1 control after reset");
    rd_exp(12'h40C, 32'h0, "R1 shadow 3 after reset");

    // R5: S_read=8, X=1, S_burn=10
    wr(A_TIME, 32'h0008_100A);
    rd_exp(A_TIME, 32'h0008_100A, "R5 timing readback");

    // R2: plain write, set alias (busy bit ignored), clear alias
    wr(A_CTRL, 32'h0000_0003);
    wr(A_CSET, 32'h3E77_0100);
    rd_exp(A_CTRL, 32'h3E77_0003, "R2 set alias, busy bit ignored");
    wr(A_CCLR, 32'h0000_0001);
    rd_exp(A_CSET, 32'h3E77_0002, "R2 clear alias");
    wr(A_CSET, 32'h0000_0001);

    // R6/R5: keyed burn of word 3
    wr(A_PDAT, 32'h0000_00F0);
    op_len("R5 burn", 13, 7, 2);
    chk(error == 1'b0, "R6 keyed burn no error", error, 0);
    rd_exp(12'h40C, 32'h0000_00F0, "R8 shadow after burn");

    // R7: OR accumulation
    wr(A_PDAT, 32'h0F00_000F);
    op_len("R7 second burn", 13, 7, 2);
    rd_exp(12'h40C, 32'h0F00_00FF, "R7 bits ORed");

    // R9: shadow override not seen by sense; R4 sense
    wr(12'h40C, 32'h1234_5678);
    rd_exp(12'h40C, 32'h1234_5678, "R9 shadow override");
    wr(A_SNS, 32'h1);
    op_len("R4 sense", 11, 5, 2);
    rd_exp(A_SDAT, 32'h0F00_00FF, "R4 sense returns fuse not shadow");
    rd_exp(12'h40C, 32'h1234_5678, "R9 override kept after sense");

    // R8: burn reloads shadow over override
    wr(A_PDAT, 32'h0000_0100);
    op_len("R8 burn", 13, 7, 2);
    rd_exp(12'h40C, 32'h0F00_01FF, "R8 shadow reloaded");

    // R6: no key
    wr(A_CCLR, 32'hFFFF_0000);
    wr(A_PDAT, 32'hFFFF_FFFF);
    chk(busy == 1'b0, "R6 locked burn does not start", busy, 0);
    chk(error == 1'b1, "R6 locked burn sets error", error, 1);
    wr(A_CTRL, 32'h0000_0003);
    wr(A_SNS, 32'h1);
    op_len("R6 sense after locked burn", 11, 5, 2);
    rd_exp(A_SDAT, 32'h0F00_01FF, "R6 fuse unchanged");

    // R3: sticky error
    chk(error == 1'b1, "R3 error survives operation", error, 1);
    wr(A_CCLR, 32'h0000_0000);
    chk(error == 1'b1, "R3 clear with bit9=0 keeps error", error, 1);
    wr(A_CTRL, 32'h0000_0003);
    chk(error == 1'b1, "R3 plain write keeps error", error, 1);
    wr(A_CCLR, 32'h0000_0200);
    chk(error == 1'b0, "R3 clear alias bit9 clears", error, 0);

    // R10: requests while busy
    wr(A_CTRL, 32'h3E77_0005);
    wr(A_PDAT, 32'h0000_00A5);
    chk(busy == 1'b1, "R10 burn running", busy, 1);
    wr(A_SNS, 32'h1);
    wr(A_PDAT, 32'h0000_5A00);
    begin
      int nb, ns, np;
      measure(nb, ns, np);
    end
    chk(error == 1'b1, "R10 busy request sets error", error, 1);
    rd_exp(12'h414, 32'h0000_00A5, "R10 second burn ignored");
    rd_exp(A_SDAT, 32'h0F00_01FF, "R10 busy sense ignored");
    wr(A_CCLR, 32'h0000_0200);

    // R11: address beyond array
    wr(A_CTRL, 32'h3E77_0014);
    wr(A_SNS, 32'h1);
    chk(busy == 1'b0, "R11 sense out of range no start", busy, 0);
    chk(error == 1'b1, "R11 sense out of range error", error, 1);
    wr(A_CCLR, 32'h0000_0200);
    wr(A_PDAT, 32'h1);
    chk(busy == 1'b0, "R11 burn out of range no start", busy, 0);
    chk(error == 1'b1, "R11 burn out of range error", error, 1);
    wr(A_CCLR, 32'h0000_0200);

    // R5 clamp: S=5, X=2 -> strobe 1, busy 2*3+1+2
    wr(A_TIME, 32'h0005_200A);
    wr(A_CTRL, 32'h0000_0005);
    wr(A_SNS, 32'h1);
    op_len("R5 clamped sense", 9, 1, 3);
    rd_exp(A_SDAT, 32'h0000_00A5, "R4 sense word 5");

    // R1: burned values return after reset
    reset_seq();
    rd_exp(A_CTRL, 32'h0, "R1 control after second reset");
    rd_exp(12'h40C, 32'h0F00_01FF, "R1 shadow 3 reloaded");
    rd_exp(12'h414, 32'h0000_00A5, "R1 shadow 5 reloaded");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 every read answered", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule